// File: doc/BRIEF.md
# Clock-and-Direction Encoder Position Counter

This block keeps a position count for an incremental encoder that signals motion as a count clock plus a separate direction level. The count clock arrives on `ti2` and the direction level on `ti1`. Both inputs are synchronized to the system clock. The selected multiplier then turns their edges into single up or down steps, at one, two or four steps per clock period of the encoder.

The counter wraps between zero and a programmable reload value. Every wrap, in either direction, sets a sticky update flag, which can raise an interrupt. Software reaches the block through a small register port. A remap control bit makes the counter read return the update flag in its top bit. A background task can then fetch the position and any pending roll-over in a single read, without racing the interrupt handler.

Register map (2-bit address): 0 = counter, 1 = reload, 2 = control, 3 = status. Control bits: [1:0] multiplier (00 off, 01 x1, 10 x2, 11 x4), [2] remap, [3] interrupt enable. Status bits: [0] update flag (write 1 to clear), [1] last step direction (1 = down). Reads are combinational on the address.

Top module: `enc_pos_counter`

## Requirements
- R1: After reset the counter reads 0, the reload reads all ones, control and status read 0, and `irq` is low.
- R2: In x1 mode (control[1:0]=01) each rising edge of `ti2` gives one step and falling edges give none. The step is up when `ti1` is low and down when `ti1` is high. A `ti2` change shows in the counter on the third rising clock edge after the change.
- R3: In x2 mode (control[1:0]=10) both edges of `ti2` give one step each, with the same direction rule as R2.
- R4: In x4 mode (control[1:0]=11) the `ti2` edges count as in x2. Each edge of `ti1` while `ti2` is steady also gives one step, whose direction comes from the `ti1` level before that edge (a rising `ti1` steps up, a falling `ti1` steps down).
- R5: With control[1:0]=00, activity on the encoder inputs leaves the counter unchanged.
- R6: An up step from the reload value gives 0 and sets the update flag.
- R7: A down step from 0 gives the reload value and sets the update flag.
- R8: The update flag stays set until a status write with bit 0 equal to 1. A status write with bit 0 equal to 0 leaves it set.
- R9: `irq` is high exactly when the update flag and control bit 3 are both set.
- R10: With control bit 2 set, a counter read returns the update flag in bit 31 from the very cycle the flag sets. Counter bit 31 still takes written data, and that data is visible once remap is cleared.
- R11: A counter write in the same cycle as a counting step wins, and the step is lost.
- R12: Status bit 1 holds the direction of the most recent step (0 up, 1 down).

Note on R4 timing: when a `ti1` edge and a `ti2` edge land in the same synchronized cycle, only the `ti2` edge counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ti1 | input | 1 | Encoder direction level, asynchronous |
| ti2 | input | 1 | Encoder count clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, combinational on `addr` |
| irq | output | 1 | Update interrupt |

## Verification
The assertions assume that the register port changes only between clock edges. They also assume each encoder input holds a level for at least one system clock, so that the synchronizer never merges two edges on the same line. They take the wrap and stickiness rules on trust only for cycles that have no counter write.

The stimulus drives every input on the falling clock edge. It holds each encoder level for five clocks, which keeps `ti1` and `ti2` edges apart in x4 mode. The single deliberate coincidence is a counter write placed on the exact cycle a synchronized `ti2` edge reaches the counter, which exercises the write-over-step rule.

// File: rtl/enc_pkg.sv
// Package: shared encodings for the encoder position counter.
// Assumes a 2-bit register address and a 4-bit control register.
package enc_pkg;

    typedef enum logic [1:0] {
        MULT_OFF = 2'b00,
        MULT_X1  = 2'b01,
        MULT_X2  = 2'b10,
        MULT_X4  = 2'b11
    } mult_e;

    localparam logic [1:0] ADR_CNT = 2'd0;
    localparam logic [1:0] ADR_RLD = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;
    localparam logic [1:0] ADR_STS = 2'd3;

    localparam int CTL_W      = 4;
    localparam int CTL_REMAP  = 2;
    localparam int CTL_IRQEN  = 3;
    localparam int STS_FLAG   = 0;
    localparam int STS_DIR    = 1;

endpackage

// File: rtl/enc_in_sync.sv
// Module: multi-stage synchronizer with edge detection for N asynchronous lines.
// Assumes each input level is held for at least one clk period.
module enc_in_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] prev,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] shreg;
            logic              last;

            // Shift the raw line through the synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shreg <= '0;
                end else begin
                    shreg <= {shreg[STAGES-2:0], raw[g]};
                end
            end

            // Keep the previous synchronized level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    last <= 1'b0;
                end else begin
                    last <= shreg[STAGES-1];
                end
            end

            assign lvl[g]  = shreg[STAGES-1];
            assign prev[g] = last;
            assign rise[g] = shreg[STAGES-1] & ~last;
            assign fall[g] = ~shreg[STAGES-1] & last;
        end
    endgenerate

endmodule

// File: rtl/enc_step_dec.sv
// Module: turns synchronized encoder edges into up/down step pulses.
// Assumes line 0 carries direction (ti1) and line 1 the count clock (ti2).
module enc_step_dec
    import enc_pkg::*;
(
    input  mult_e mult,
    input  logic  dir_lvl,
    input  logic  dir_prev,
    input  logic  dir_rise,
    input  logic  dir_fall,
    input  logic  clk_rise,
    input  logic  clk_fall,
    output logic  step_up,
    output logic  step_dn
);

    logic clk_evt;
    logic dir_evt;
    logic down;

    // Choose which edges count and which level gives the direction.
    always_comb begin
        clk_evt = 1'b0;
        dir_evt = 1'b0;
        unique case (mult)
            MULT_X1: clk_evt = clk_rise;
            MULT_X2: clk_evt = clk_rise | clk_fall;
            MULT_X4: begin
                clk_evt = clk_rise | clk_fall;
                dir_evt = (dir_rise | dir_fall) & ~(clk_rise | clk_fall);
            end
            default: ;
        endcase
        down    = clk_evt ? dir_lvl : dir_prev;
        step_up = (clk_evt | dir_evt) & ~down;
        step_dn = (clk_evt | dir_evt) & down;
    end

endmodule

// File: rtl/enc_count_core.sv
// Module: wrap-around position counter between 0 and a reload value.
// Assumes step_up and step_dn are never high together; a write wins over a step.
module enc_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic [W-1:0] reload,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         dir_dn
);

    logic [W-1:0] cnt_d;

    // Compute the next count, the wrap pulse and apply write priority.
    always_comb begin
        cnt_d = cnt;
        wrap  = 1'b0;
        if (step_up) begin
            if (cnt == reload) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt + 1'b1;
            end
        end else if (step_dn) begin
            if (cnt == '0) begin
                cnt_d = reload;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt - 1'b1;
            end
        end
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
            wrap  = 1'b0;
        end
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

    // Record the direction of the latest step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_dn <= 1'b0;
        end else if (step_up | step_dn) begin
            dir_dn <= step_dn;
        end
    end

endmodule

// File: rtl/enc_pos_counter.sv
// Module: top of the encoder position counter with register port and flag remap.
// Assumes register port inputs are stable around the rising clk edge.
module enc_pos_counter
    import enc_pkg::*;
#(
    parameter int               CNT_W       = 32,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ti1,
    input  logic             ti2,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    localparam int TOP = CNT_W - 1;

    logic [1:0]       s_lvl, s_prev, s_rise, s_fall;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [CTL_W-1:0] ctl_q;
    logic             uflag_q;
    logic             step_up, step_dn, wrap, dir_dn;
    logic             cnt_wr, rld_wr, ctl_wr, sts_clr;
    mult_e            mult;

    assign cnt_wr  = wr_en && (addr == ADR_CNT);
    assign rld_wr  = wr_en && (addr == ADR_RLD);
    assign ctl_wr  = wr_en && (addr == ADR_CTL);
    assign sts_clr = wr_en && (addr == ADR_STS) && wr_data[STS_FLAG];
    assign mult    = mult_e'(ctl_q[1:0]);

    enc_in_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({ti2, ti1}),
        .lvl  (s_lvl),
        .prev (s_prev),
        .rise (s_rise),
        .fall (s_fall)
    );

    enc_step_dec u_dec (
        .mult    (mult),
        .dir_lvl (s_lvl[0]),
        .dir_prev(s_prev[0]),
        .dir_rise(s_rise[0]),
        .dir_fall(s_fall[0]),
        .clk_rise(s_rise[1]),
        .clk_fall(s_fall[1]),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    enc_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .reload   (reload_q),
        .cnt_wr   (cnt_wr),
        .cnt_wdata(wr_data),
        .cnt      (cnt_q),
        .wrap     (wrap),
        .dir_dn   (dir_dn)
    );

    // Reload and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RELOAD_INIT;
            ctl_q    <= '0;
        end else begin
            if (rld_wr) reload_q <= wr_data;
            if (ctl_wr) ctl_q    <= wr_data[CTL_W-1:0];
        end
    end

    // Sticky update flag: a wrap sets it, a write of one clears it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uflag_q <= 1'b0;
        end else if (wrap) begin
            uflag_q <= 1'b1;
        end else if (sts_clr) begin
            uflag_q <= 1'b0;
        end
    end

    // Read mux, with the flag copied into the counter top bit under remap.
    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADR_CNT: begin
                rd_data = cnt_q;
                if (ctl_q[CTL_REMAP]) rd_data[TOP] = uflag_q;
            end
            ADR_RLD: rd_data = reload_q;
            ADR_CTL: rd_data[CTL_W-1:0] = ctl_q;
            ADR_STS: begin
                rd_data[STS_FLAG] = uflag_q;
                rd_data[STS_DIR]  = dir_dn;
            end
            default: ;
        endcase
    end

    assign irq = uflag_q & ctl_q[CTL_IRQEN];

endmodule

// File: rtl/enc_pos_counter_chk.sv
// Module: property checker for enc_pos_counter, attached through bind.
// Assumes it observes the top ports and a few internal state signals.
module enc_pos_counter_chk
    import enc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] rd_data,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             uflag,
    input logic             step_up,
    input logic             step_dn,
    input logic [CTL_W-1:0] ctl
);

    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == ADR_CNT);

    AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn})); // R4
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && cnt == reload && !cnt_wr) |=> (cnt == '0 && uflag)); // R6
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && cnt == '0 && !cnt_wr) |=> (cnt == $past(reload) && uflag)); // R7
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wr_data))); // R11
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1:0] == 2'b00 && !cnt_wr) |=> $stable(cnt)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uflag && !(wr_en && addr == ADR_STS && wr_data[STS_FLAG])) |=> uflag); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> uflag); // R9
    AST_REMAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CTL_REMAP] && addr == ADR_CNT) |-> (rd_data[CNT_W-1] == uflag)); // R10

endmodule

bind enc_pos_counter enc_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .irq    (irq),
    .cnt    (cnt_q),
    .reload (reload_q),
    .uflag  (uflag_q),
    .step_up(step_up),
    .step_dn(step_dn),
    .ctl    (ctl_q)
);

// File: tb/sim_enc_pos_counter.sv
// Bench: directed scenarios for enc_pos_counter, one task each.
module sim_enc_pos_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ti1 = 1'b0;
    logic        ti2 = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    enc_pos_counter u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ti1    (ti1),
        .ti2    (ti2),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .irq    (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_ti2(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ti2 = 1'b1; settle();
            ti2 = 1'b0; settle();
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 counter", v, 32'h0);
        rd(2'd1, v); chk("R1 reload", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 control", v, 32'h0);
        rd(2'd3, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_off();
        logic [31:0] v;
        pulse_ti2(3);
        @(negedge clk); ti1 = 1'b1; settle(); ti1 = 1'b0; settle();
        rd(2'd0, v); chk("R5 off mode holds", v, 32'h0);
    endtask

    task automatic t_x1();
        logic [31:0] v;
        wr(2'd2, 32'h1);
        @(negedge clk); ti2 = 1'b1; settle();
        rd(2'd0, v); chk("R2 x1 rise", v, 32'd1);
        ti2 = 1'b0; settle();
        rd(2'd0, v); chk("R2 x1 fall ignored", v, 32'd1);
        pulse_ti2(3);
        rd(2'd0, v); chk("R2 x1 up", v, 32'd4);
        rd(2'd3, v); chk("R12 dir up", v & 32'h2, 32'h0);
        @(negedge clk); ti1 = 1'b1; settle();
        pulse_ti2(2);
        rd(2'd0, v); chk("R2 x1 down", v, 32'd2);
        rd(2'd3, v); chk("R12 dir down", v & 32'h2, 32'h2);
        ti1 = 1'b0; settle();
    endtask

    task automatic t_x2();
        logic [31:0] v;
        wr(2'd2, 32'h2);
        wr(2'd0, 32'd0);
        pulse_ti2(3);
        rd(2'd0, v); chk("R3 x2 both edges", v, 32'd6);
    endtask

    task automatic t_x4();
        logic [31:0] v;
        wr(2'd2, 32'h3);
        wr(2'd0, 32'd0);
        @(negedge clk); ti2 = 1'b1; settle();
        rd(2'd0, v); chk("R4 x4 ti2 rise", v, 32'd1);
        ti1 = 1'b1; settle();
        rd(2'd0, v); chk("R4 x4 ti1 rise up", v, 32'd2);
        rd(2'd3, v); chk("R12 x4 dir up", v & 32'h2, 32'h0);
        ti2 = 1'b0; settle();
        rd(2'd0, v); chk("R4 x4 ti2 fall down", v, 32'd1);
        ti1 = 1'b0; settle();
        rd(2'd0, v); chk("R4 x4 ti1 fall down", v, 32'd0);
    endtask

    task automatic t_wrap_up();
        logic [31:0] v;
        wr(2'd2, 32'h1);
        wr(2'd1, 32'd9);
        wr(2'd0, 32'd8);
        pulse_ti2(1);
        rd(2'd0, v); chk("R6 reach reload", v, 32'd9);
        rd(2'd3, v); chk("R6 no flag yet", v & 32'h1, 32'h0);
        pulse_ti2(1);
        rd(2'd0, v); chk("R6 wrap to zero", v, 32'd0);
        rd(2'd3, v); chk("R6 flag set", v & 32'h1, 32'h1);
        chk("R9 irq masked", {31'd0, irq}, 32'h0);
        wr(2'd2, 32'h9);
        #1; chk("R9 irq enabled", {31'd0, irq}, 32'h1);
        wr(2'd3, 32'h0);
        rd(2'd3, v); chk("R8 zero write keeps flag", v & 32'h1, 32'h1);
        wr(2'd3, 32'h1);
        rd(2'd3, v); chk("R8 w1c clears", v & 32'h1, 32'h0);
        #1; chk("R9 irq follows flag", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_wrap_down();
        logic [31:0] v;
        wr(2'd2, 32'h1);
        wr(2'd0, 32'd1);
        @(negedge clk); ti1 = 1'b1; settle();
        pulse_ti2(1);
        rd(2'd0, v); chk("R7 reach zero", v, 32'd0);
        pulse_ti2(1);
        rd(2'd0, v); chk("R7 wrap to reload", v, 32'd9);
        rd(2'd3, v); chk("R7 flag set", v & 32'h1, 32'h1);
        ti1 = 1'b0; settle();
    endtask

    task automatic t_remap();
        logic [31:0] v;
        wr(2'd2, 32'h5);
        rd(2'd0, v); chk("R10 flag in bit31", v, 32'h8000_0009);
        wr(2'd0, 32'h8000_0003);
        wr(2'd3, 32'h1);
        rd(2'd0, v); chk("R10 bit31 hidden", v, 32'h0000_0003);
        wr(2'd2, 32'h1);
        rd(2'd0, v); chk("R10 bit31 was written", v, 32'h8000_0003);
        wr(2'd2, 32'h5);
        wr(2'd0, 32'd9);
        @(negedge clk); ti2 = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R10 before wrap", v, 32'h0000_0009);
        @(negedge clk);
        rd(2'd0, v); chk("R10 same cycle copy", v, 32'h8000_0000);
        rd(2'd3, v); chk("R10 flag with copy", v & 32'h1, 32'h1);
        settle(); ti2 = 1'b0; settle();
        wr(2'd3, 32'h1);
    endtask

    task automatic t_wr_prio();
        logic [31:0] v;
        wr(2'd2, 32'h1);
        wr(2'd1, 32'd100);
        wr(2'd0, 32'd5);
        @(negedge clk); ti2 = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wr_data = 32'd20;
        @(negedge clk); wr_en = 1'b0;
        settle();
        rd(2'd0, v); chk("R11 write beats step", v, 32'd20);
        ti2 = 1'b0; settle();
        pulse_ti2(1);
        rd(2'd0, v); chk("R11 counting resumes", v, 32'd21);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_x1();
        t_x2();
        t_x4();
        t_wrap_up();
        t_wrap_down();
        t_remap();
        t_wr_prio();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule